// File: doc/BRIEF.md
# DRAM Burst Column Address Generator

This block turns one burst request into the run of column addresses that a DDR SDRAM read or write burst visits. A controller presents a start column, a burst-length code, an ordering type and a one-cycle start strobe. The block then emits one column per cycle, one for each data beat. It flags the first beat and the last beat of the burst.

The burst occupies a naturally aligned block whose size is the burst length. The column bits above that block are copied from the start column and do not change. The low bits walk the block in one of two ways. In sequential order they count up and wrap inside the block. In interleaved order, beat k uses the start offset XOR k.

The column can also be spread onto a device address bus. When the column is wider than ten bits, address position 10 is skipped and held low, because it is not a column bit. The upper column bits sit one place higher on the bus.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, beat_valid, first, last, busy and err are all 0.
- R2: A start taken while busy is 0 with a legal code makes the next clock edge output beat 0. Beat 0 equals start_col, with first=1 and beat_valid=1. The block then emits exactly L beats on consecutive cycles. Only the final beat has last=1. blen_code encodes L as 01=2, 10=4 and 11=8.
- R3: With btype=0 (sequential), beat k has low bits ((s + k) mod L). Here s is the start column's offset within its L-aligned block.
- R4: With btype=1 (interleaved), beat k has low bits (s XOR k).
- R5: Column bits at or above log2(L) equal those of start_col on every beat. A wrap inside the block never carries upward. For L=2, both types give the same order.
- R6: A start strobe raised while busy=1 has no effect on the beats that follow.
- R7: A start with blen_code 00 produces no beat, leaves busy at 0, and sets err=1 on the next edge. err stays 1 until a legal start is taken, and falls on that start's first beat.
- R8: A start may be taken in the cycle that shows the last beat. The next burst's first beat then follows with no gap.
- R9: When COL_W > 10, addr_pins[9:0] equals beat_col[9:0], addr_pins[10] is 0, and addr_pins[COL_W:11] equals beat_col[COL_W-1:10]. Otherwise addr_pins equals beat_col.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request strobe |
| start_col | input | COL_W | First column of the burst |
| blen_code | input | 2 | Burst length: 01=2, 10=4, 11=8, 00 illegal |
| btype | input | 1 | 0 sequential, 1 interleaved |
| busy | output | 1 | More beats of the current burst remain |
| beat_valid | output | 1 | A beat column is presented |
| beat_col | output | COL_W | Column of the current beat |
| addr_pins | output | ADDR_W | Column spread onto the address bus |
| first | output | 1 | Current beat is beat 0 |
| last | output | 1 | Current beat is the final beat |
| err | output | 1 | Last start carried an illegal length code |

## Verification
The assertions assume that start_col, blen_code and btype matter only in the cycle a start is taken. Between bursts the bench changes them freely, including while busy is high. The upper-bit check assumes that consecutive valid non-first beats belong to one burst. The stimulus keeps this true, because a new burst always opens with first set, even when bursts run back to back. Every start offset is paired with randomized upper column bits, so that a wrap that carries upward would show.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int OFF_W = 3;

  typedef enum logic [1:0] {
    BL_BAD = 2'b00,
    BL_2   = 2'b01,
    BL_4   = 2'b10,
    BL_8   = 2'b11
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
(
  input  logic [1:0]       code,
  output logic             legal,
  output logic [OFF_W-1:0] mask
);
  always_comb begin
    legal = 1'b1;
    case (blen_e'(code))
      BL_2:    mask = 3'b001;
      BL_4:    mask = 3'b011;
      BL_8:    mask = 3'b111;
      default: begin
        mask  = 3'b000;
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bcg_order.sv
module bcg_order
  import bcg_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [OFF_W-1:0] step,
  input  logic [OFF_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  localparam int HI_W = COL_W - OFF_W;

  logic [OFF_W-1:0] seq_off;
  logic [OFF_W-1:0] ilv_off;
  logic [OFF_W-1:0] walk;
  logic [OFF_W-1:0] low;

  always_comb begin
    seq_off = base_col[OFF_W-1:0] + step;
    ilv_off = base_col[OFF_W-1:0] ^ step;
    walk    = ilv ? ilv_off : seq_off;
    // bits inside the block follow the walk, the rest keep the start value
    low     = (walk & mask) | (base_col[OFF_W-1:0] & ~mask);
    col     = {base_col[COL_W-1 -: HI_W], low};
  end
endmodule

// File: rtl/bcg_pin_map.sv
module bcg_pin_map #(
  parameter int COL_W   = 10,
  parameter int ADDR_W  = 10,
  parameter int GAP_POS = 10
) (
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] pins
);
  generate
    if (ADDR_W > COL_W) begin : g_gap
      assign pins[GAP_POS-1:0] = col[GAP_POS-1:0];
      assign pins[GAP_POS]     = 1'b0;
      for (genvar i = GAP_POS; i < COL_W; i++) begin : g_up
        assign pins[i+1] = col[i];
      end
    end else begin : g_flat
      assign pins = col;
    end
  endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int GAP_POS = 10,
  parameter int ADDR_W  = (COL_W > GAP_POS) ? COL_W + 1 : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [1:0]        blen_code,
  input  logic              btype,
  output logic              busy,
  output logic              beat_valid,
  output logic [COL_W-1:0]  beat_col,
  output logic [ADDR_W-1:0] addr_pins,
  output logic              first,
  output logic              last,
  output logic              err
);
  logic [COL_W-1:0] base_q;
  logic [OFF_W-1:0] mask_q;
  logic             ilv_q;
  logic [OFF_W-1:0] step_q;
  logic [OFF_W-1:0] rem_q;

  logic             dec_legal;
  logic [OFF_W-1:0] dec_mask;
  logic             accept;
  logic [COL_W-1:0] ord_base;
  logic [OFF_W-1:0] ord_step;
  logic [OFF_W-1:0] ord_mask;
  logic             ord_ilv;
  logic [COL_W-1:0] ord_col;

  bcg_len_decode u_dec (
    .code  (blen_code),
    .legal (dec_legal),
    .mask  (dec_mask)
  );

  assign accept = start && (rem_q == '0);

  always_comb begin
    if (accept) begin
      ord_base = start_col;
      ord_step = '0;
      ord_mask = dec_mask;
      ord_ilv  = btype;
    end else begin
      ord_base = base_q;
      ord_step = step_q;
      ord_mask = mask_q;
      ord_ilv  = ilv_q;
    end
  end

  bcg_order #(.COL_W(COL_W)) u_ord (
    .base_col (ord_base),
    .step     (ord_step),
    .mask     (ord_mask),
    .ilv      (ord_ilv),
    .col      (ord_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      mask_q     <= '0;
      ilv_q      <= 1'b0;
      step_q     <= '0;
      rem_q      <= '0;
      beat_valid <= 1'b0;
      beat_col   <= '0;
      first      <= 1'b0;
      last       <= 1'b0;
      err        <= 1'b0;
    end else begin
      beat_valid <= 1'b0;
      first      <= 1'b0;
      last       <= 1'b0;
      if (accept) begin
        if (dec_legal) begin
          base_q     <= start_col;
          mask_q     <= dec_mask;
          ilv_q      <= btype;
          step_q     <= 3'd1;
          rem_q      <= dec_mask;
          beat_valid <= 1'b1;
          beat_col   <= ord_col;
          first      <= 1'b1;
          err        <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end else if (rem_q != '0) begin
        beat_valid <= 1'b1;
        beat_col   <= ord_col;
        step_q     <= step_q + 3'd1;
        rem_q      <= rem_q - 3'd1;
        last       <= (rem_q == 3'd1);
      end
    end
  end

  assign busy = (rem_q != '0);

  bcg_pin_map #(.COL_W(COL_W), .ADDR_W(ADDR_W), .GAP_POS(GAP_POS)) u_map (
    .col  (beat_col),
    .pins (addr_pins)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W   = 10,
  parameter int GAP_POS = 10,
  parameter int ADDR_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        blen_code,
  input logic              busy,
  input logic              beat_valid,
  input logic [COL_W-1:0]  beat_col,
  input logic [ADDR_W-1:0] addr_pins,
  input logic              first,
  input logic              last,
  input logic              err
);
  // R5: bits above the largest block never move within a burst
  a_r5_upper_frozen: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !first) |-> (beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3])));

  // R2: a first beat is a valid beat and never also the last
  a_r2_first_shape: assert property (@(posedge clk) disable iff (rst)
    first |-> (beat_valid && !last));

  // R2: beats after the first continue without gap until last
  a_r2_no_gap: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !last) |=> beat_valid);

  // R8: after the last beat comes either idle or a fresh burst
  a_r8_after_last: assert property (@(posedge clk) disable iff (rst)
    last |=> (!beat_valid || first));

  // R6: a start while busy does not restart the burst
  a_r6_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> (beat_valid && !first));

  // R7: an illegal length code yields no beat and raises err
  a_r7_illegal: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && blen_code == 2'b00) |=> (err && !beat_valid && !busy));

  generate
    if (ADDR_W > COL_W) begin : g_gap_chk
      // R9: the skipped pin stays low, upper bits shift up
      a_r9_gap_low: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (addr_pins[GAP_POS] == 1'b0 &&
                        addr_pins[ADDR_W-1:GAP_POS+1] == beat_col[COL_W-1:GAP_POS]));
    end else begin : g_flat_chk
      // R9: flat mapping
      a_r9_flat: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (addr_pins == beat_col));
    end
  endgenerate
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W), .GAP_POS(GAP_POS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .blen_code  (blen_code),
  .busy       (busy),
  .beat_valid (beat_valid),
  .beat_col   (beat_col),
  .addr_pins  (addr_pins),
  .first      (first),
  .last       (last),
  .err        (err)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int COL_W  = 11;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [COL_W-1:0]  start_col = '0;
  logic [1:0]        blen_code = 2'b01;
  logic              btype = 1'b0;
  logic              busy, beat_valid, first, last, err;
  logic [COL_W-1:0]  beat_col;
  logic [ADDR_W-1:0] addr_pins;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int  pend_q[$];
  int  pend_first[$];
  int  pend_last[$];
  bit  m_valid = 0, m_first = 0, m_last = 0, m_err = 0;
  int  m_col = 0;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .blen_code(blen_code), .btype(btype), .busy(busy),
    .beat_valid(beat_valid), .beat_col(beat_col), .addr_pins(addr_pins),
    .first(first), .last(last), .err(err)
  );

  function automatic int len_of(input logic [1:0] c);
    return (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : (c == 2'b11) ? 8 : 0;
  endfunction

  function automatic logic [ADDR_W-1:0] spread(input int c);
    logic [ADDR_W-1:0] p;
    p = '0;
    for (int i = 0; i < COL_W; i++)
      p[(i < 10) ? i : i + 1] = c[i];
    return p;
  endfunction

  // behavioural model: beats are queued as whole integers
  always @(posedge clk) begin
    if (rst) begin
      pend_q.delete(); pend_first.delete(); pend_last.delete();
      m_valid = 0; m_first = 0; m_last = 0; m_err = 0;
    end else begin
      m_valid = 0; m_first = 0; m_last = 0;
      if (pend_q.size() == 0 && start) begin
        int n;
        n = len_of(blen_code);
        if (n == 0) m_err = 1;
        else begin
          int s, blk;
          m_err = 0;
          s   = int'(start_col) % n;
          blk = int'(start_col) - s;
          for (int k = 0; k < n; k++) begin
            int o;
            o = btype ? (s ^ k) : ((s + k) % n);
            pend_q.push_back(blk + o);
            pend_first.push_back(k == 0);
            pend_last.push_back(k == n - 1);
          end
        end
      end
      if (pend_q.size() > 0) begin
        m_valid = 1;
        m_col   = pend_q.pop_front();
        m_first = pend_first.pop_front();
        m_last  = pend_last.pop_front();
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      bit bad;
      bad = (beat_valid !== m_valid) || (first !== m_first) || (last !== m_last) ||
            (err !== m_err) || (busy !== (pend_q.size() > 0));
      if (m_valid)
        bad = bad || (int'(beat_col) != m_col) || (addr_pins !== spread(m_col));
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s t=%0t act v=%0b col=%0d pins=%0h f=%0b l=%0b e=%0b b=%0b exp v=%0b col=%0d pins=%0h f=%0b l=%0b e=%0b b=%0b",
                 tag, $time, beat_valid, beat_col, addr_pins, first, last, err, busy,
                 m_valid, m_col, spread(m_col), m_first, m_last, m_err, pend_q.size() > 0);
      end
    end
  end

  task automatic pulse(input int col, input logic [1:0] code, input logic typ);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(col); blen_code = code; btype = typ;
    @(negedge clk);
    start = 1'b0;
    start_col = ~start_col;   // inputs wander after acceptance (R6)
    btype = ~typ;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (beat_valid || first || last || busy || err) begin
      fails++;
      $display("FAIL R1 act v=%0b f=%0b l=%0b b=%0b e=%0b exp all 0",
               beat_valid, first, last, busy, err);
    end
    // R2 R3 R4 R5: every length, type and start offset, random upper bits
    for (int c = 1; c < 4; c++)
      for (int t = 0; t < 2; t++)
        for (int o = 0; o < 8; o++) begin
          tag = (t == 0) ? "R3" : "R4";
          pulse(($urandom_range(0, 255) << 3) | o, 2'(c), 1'(t));
        end
    // R5: wraps at the top of the column range
    tag = "R5";
    pulse(2047, 2'b11, 1'b0);
    pulse(2045, 2'b10, 1'b1);
    pulse(1023, 2'b11, 1'b0);
    // R7: illegal code, then clear with a legal start
    tag = "R7";
    pulse(12, 2'b00, 1'b0);
    repeat (2) @(negedge clk);
    pulse(12, 2'b10, 1'b0);
    // R6 R8: start held high across bursts
    tag = "R8";
    @(negedge clk);
    start = 1'b1; start_col = 11'd1029; blen_code = 2'b10; btype = 1'b1;
    repeat (2) @(negedge clk);
    tag = "R6";
    start_col = 11'd6; blen_code = 2'b11; btype = 1'b0;
    repeat (12) @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    // R9 is checked on every beat via addr_pins
    tag = "R9";
    pulse(11'h7FA, 2'b11, 1'b1);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog act=%0d cycles exp=done", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule